// File: doc/BRIEF.md
# Background ROM Read and RAM Write Buffer Unit

This unit sits between a small coprocessor core and its slow program ROM and work RAM. It hides the latency of both memories behind countdown-timed background transactions. When the core writes its ROM pointer, the unit starts a timed read. The fetched byte lands in a read buffer that the core collects later. When the core stores a byte to RAM, the unit posts the address and data into a one-entry buffer. The buffer commits to memory once its own countdown runs out, while the core carries on.

Each countdown lasts five cycles when the fast clock is selected and six when it is not. A new access to a busy path first waits for the outstanding transaction to drain. Neither memory is touched unless the host has granted the core access to it. While a grant is withheld, the unit asserts `stall` to freeze the core, and it releases the stall in the cycle the grant returns.

Top module: `bg_mem_access`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transaction, both countdowns are empty. `stall`, `rom_pending`, `rom_rd`, `ram_we` and `ram_re` are 0, `rd_buf` is 0, and no stale access follows.
- R2: A pointer write sampled at a clock edge loads a ROM countdown of 5 cycles (`fast_sel`=1) or 6 cycles (`fast_sel`=0). `rom_rd` is high in exactly the 5th or 6th cycle after that edge.
- R3: A ROM read takes place at address {`rom_bank`, pointer} with the pointer in the low 16 bits. The byte appears on `rd_buf` from the next cycle onward. `rom_pending` is 1 from the pointer write until that read.
- R4: A pointer write while a ROM countdown is running restarts the countdown with the new pointer. This includes a write in the very cycle the read would have occurred, which suppresses that read. Only the last pointer is read.
- R5: A buffer read request while the ROM countdown is non-zero stalls the core. It is acknowledged (`buf_ack`) in the first cycle the countdown is empty, and returns the freshly read byte.
- R6: A RAM store accepted while the RAM path is idle latches address and data. It pulses `ram_we` in the 5th or 6th following cycle at address {0x70 + `ram_bank`, address}.
- R7: A RAM store issued while the RAM countdown is non-zero stalls until that countdown has drained. A second store immediately after a first one waits exactly one full delay.
- R8: A RAM load is held off while a posted write is outstanding, while a store is requested in the same cycle, or while the RAM grant is low. When the load is accepted, `ram_re` and `ld_ack` are high for one cycle at {0x70 + `ram_bank`, address}, and `ld_data` returns the memory byte.
- R9: If a grant is low when a countdown reaches its final cycle, the access is withheld, the countdown holds and `stall` is high. The access happens in the first cycle the grant is high again.
- R10: `stall` is high exactly when a ROM-side wait or a RAM-side wait is present. With no request and no withheld access it is 0.
- R11: The clock-select input is sampled only when a countdown is loaded. Changing it during a countdown does not alter that countdown's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_sel | input | 1 | 1 selects the 5-cycle delay, 0 the 6-cycle delay |
| ptr_wr | input | 1 | ROM pointer write strobe |
| ptr_val | input | 16 | New ROM pointer value |
| rom_bank | input | 8 | ROM bank, upper address byte of ROM reads |
| rom_grant | input | 1 | Host allows core ROM access |
| buf_rd_req | input | 1 | Core requests the ROM read buffer |
| buf_ack | output | 1 | Buffer request served this cycle |
| rd_buf | output | 8 | ROM read buffer |
| rom_pending | output | 1 | ROM read in flight |
| st_req | input | 1 | RAM store request |
| st_addr | input | 16 | RAM store offset |
| st_data | input | 8 | RAM store byte |
| ld_req | input | 1 | RAM load request |
| ld_addr | input | 16 | RAM load offset |
| ld_ack | output | 1 | Load served this cycle |
| ld_data | output | 8 | Loaded byte, valid with ld_ack |
| ram_bank | input | 8 | RAM bank, added to 0x70 |
| ram_grant | input | 1 | Host allows core RAM access |
| stall | output | 1 | Freeze the core |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 24 | ROM address |
| rom_rdata | input | 8 | ROM data, same cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | 24 | RAM address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM data, same cycle |

## Verification
The bench aims a pointer write at the exact cycle of the pending read. A design that let the old read through would show an extra `rom_rd` pulse and a stale buffer byte. It also switches the clock select in the middle of a countdown. A unit that re-evaluated the delay every cycle would fire one cycle late. Back-to-back stores, and a load issued behind a posted write, show whether the unit drains first. A design that did not would drop the first write or read the old byte. Grants are withheld across the final countdown cycle. A unit that ignored them would touch memory without permission, and one that lost the countdown would never complete the access.

// File: rtl/bg_mem_pkg.sv
package bg_mem_pkg;

  typedef enum logic [1:0] {
    CD_IDLE  = 2'd0,
    CD_COUNT = 2'd1,
    CD_LAST  = 2'd2
  } cd_phase_e;

  // Delay chosen at load time from the clock select.
  function automatic int unsigned pick_delay(input logic fast,
                                             input int unsigned fast_dly,
                                             input int unsigned slow_dly);
    return fast ? fast_dly : slow_dly;
  endfunction

endpackage

// File: rtl/bg_countdown.sv
module bg_countdown
  import bg_mem_pkg::*;
#(
  parameter int unsigned FAST_DLY = 5,
  parameter int unsigned SLOW_DLY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic fast_sel,
  input  logic grant,
  output logic busy,
  output logic fire,
  output logic blocked
);
  localparam int unsigned MAX_DLY = (SLOW_DLY > FAST_DLY) ? SLOW_DLY : FAST_DLY;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_DLY);

  // Saturating step: never below one while a transaction is outstanding.
  function automatic logic [CNT_W-1:0] sat_dec(input logic [CNT_W-1:0] v);
    return (v > ONE_C) ? v - ONE_C : v;
  endfunction

  function automatic cd_phase_e phase_of(input logic [CNT_W-1:0] v);
    if (v == '0)    return CD_IDLE;
    if (v == ONE_C) return CD_LAST;
    return CD_COUNT;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d, reload;
  cd_phase_e        phase;
  logic             last;

  assign reload  = CNT_W'(pick_delay(fast_sel, FAST_DLY, SLOW_DLY));
  assign phase   = phase_of(cnt_q);
  assign busy    = (phase != CD_IDLE);
  assign last    = (phase == CD_LAST);
  assign fire    = last && grant && !load;
  assign blocked = last && !grant && !load;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = reload;
    else if (fire) cnt_d = '0;
    else           cnt_d = sat_dec(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: count never exceeds the longer delay
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_C);
  // R2: a load always leaves a transaction in flight
  a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  // R9: a withheld access keeps waiting in its final cycle
  a_r9_blocked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> last);
  // R3: after the access the path is idle
  a_r3_fire_idles: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy);

endmodule

// File: rtl/bg_rom_reader.sv
module bg_rom_reader #(
  parameter int unsigned PTR_W    = 16,
  parameter int unsigned BANK_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FAST_DLY = 5,
  parameter int unsigned SLOW_DLY = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fast_sel,
  input  logic                      ptr_wr,
  input  logic [PTR_W-1:0]          ptr_val,
  input  logic [BANK_W-1:0]         rom_bank,
  input  logic                      rom_grant,
  input  logic                      buf_rd_req,
  input  logic [DATA_W-1:0]         rom_rdata,
  output logic                      rom_rd,
  output logic [BANK_W+PTR_W-1:0]   rom_addr,
  output logic [DATA_W-1:0]         rd_buf,
  output logic                      buf_ack,
  output logic                      pending,
  output logic                      rom_wait
);
  localparam int unsigned ADDR_W = BANK_W + PTR_W;

  function automatic logic [ADDR_W-1:0] rom_loc(input logic [BANK_W-1:0] b,
                                                input logic [PTR_W-1:0] p);
    return {b, p};
  endfunction

  logic              busy, fire, blocked;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] buf_q;
  logic              pend_q;

  bg_countdown #(.FAST_DLY(FAST_DLY), .SLOW_DLY(SLOW_DLY)) u_cd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_wr),
    .fast_sel(fast_sel),
    .grant   (rom_grant),
    .busy    (busy),
    .fire    (fire),
    .blocked (blocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      buf_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ptr_wr) begin
        ptr_q  <= ptr_val;
        pend_q <= 1'b1;
      end else if (fire) begin
        buf_q  <= rom_rdata;
        pend_q <= 1'b0;
      end
    end
  end

  assign rom_rd   = fire;
  assign rom_addr = rom_loc(rom_bank, ptr_q);
  assign rd_buf   = buf_q;
  assign pending  = pend_q;
  assign buf_ack  = buf_rd_req && !busy;
  assign rom_wait = blocked || (buf_rd_req && busy);

  // R3: pending flag and countdown agree
  a_r3_pending_matches: assert property (@(posedge clk) disable iff (!rst_n)
    pending == busy);
  // R3: the buffer captures the byte of the read
  a_r3_buf_captures: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> rd_buf == $past(rom_rdata));
  // R5: the buffer changes only through a read
  a_r5_buf_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_rd |=> $stable(rd_buf));

endmodule

// File: rtl/bg_ram_poster.sv
module bg_ram_poster #(
  parameter int unsigned PTR_W         = 16,
  parameter int unsigned BANK_W        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned FAST_DLY      = 5,
  parameter int unsigned SLOW_DLY      = 6,
  parameter int unsigned RAM_BASE_BANK = 'h70
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fast_sel,
  input  logic                      st_req,
  input  logic [PTR_W-1:0]          st_addr,
  input  logic [DATA_W-1:0]         st_data,
  input  logic                      ld_req,
  input  logic [PTR_W-1:0]          ld_addr,
  input  logic [BANK_W-1:0]         ram_bank,
  input  logic                      ram_grant,
  input  logic [DATA_W-1:0]         ram_rdata,
  output logic                      ram_we,
  output logic                      ram_re,
  output logic [BANK_W+PTR_W-1:0]   ram_addr,
  output logic [DATA_W-1:0]         ram_wdata,
  output logic                      ld_ack,
  output logic [DATA_W-1:0]         ld_data,
  output logic                      ram_wait
);
  localparam int unsigned ADDR_W = BANK_W + PTR_W;
  localparam logic [BANK_W-1:0] BASE_C = BANK_W'(RAM_BASE_BANK);

  function automatic logic [ADDR_W-1:0] ram_loc(input logic [BANK_W-1:0] b,
                                                input logic [PTR_W-1:0] a);
    return {BASE_C + b, a};
  endfunction

  logic              busy, fire, blocked, post, ld_go;
  logic [PTR_W-1:0]  waddr_q;
  logic [DATA_W-1:0] wdata_q;

  assign post  = st_req && !busy;
  assign ld_go = ld_req && !st_req && !busy && ram_grant;

  bg_countdown #(.FAST_DLY(FAST_DLY), .SLOW_DLY(SLOW_DLY)) u_cd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (post),
    .fast_sel(fast_sel),
    .grant   (ram_grant),
    .busy    (busy),
    .fire    (fire),
    .blocked (blocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (post) begin
      waddr_q <= st_addr;
      wdata_q <= st_data;
    end
  end

  assign ram_we    = fire;
  assign ram_re    = ld_go;
  assign ram_wdata = wdata_q;
  assign ram_addr  = fire ? ram_loc(ram_bank, waddr_q) : ram_loc(ram_bank, ld_addr);
  assign ld_ack    = ld_go;
  assign ld_data   = ram_rdata;
  assign ram_wait  = blocked || (st_req && busy) || (ld_req && !ld_go);

  // R8: a read never overlaps a posted write
  a_r8_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> !busy);
  // R6: after a commit the buffer is free
  a_r6_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !busy);
  // R7: a stalled store is not accepted
  a_r7_store_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && busy && !fire) |=> busy);

endmodule

// File: rtl/bg_mem_access.sv
module bg_mem_access #(
  parameter int unsigned PTR_W         = 16,
  parameter int unsigned BANK_W        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned FAST_DLY      = 5,
  parameter int unsigned SLOW_DLY      = 6,
  parameter int unsigned RAM_BASE_BANK = 'h70
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fast_sel,
  input  logic                    ptr_wr,
  input  logic [PTR_W-1:0]        ptr_val,
  input  logic [BANK_W-1:0]       rom_bank,
  input  logic                    rom_grant,
  input  logic                    buf_rd_req,
  output logic                    buf_ack,
  output logic [DATA_W-1:0]       rd_buf,
  output logic                    rom_pending,
  input  logic                    st_req,
  input  logic [PTR_W-1:0]        st_addr,
  input  logic [DATA_W-1:0]       st_data,
  input  logic                    ld_req,
  input  logic [PTR_W-1:0]        ld_addr,
  output logic                    ld_ack,
  output logic [DATA_W-1:0]       ld_data,
  input  logic [BANK_W-1:0]       ram_bank,
  input  logic                    ram_grant,
  output logic                    stall,
  output logic                    rom_rd,
  output logic [BANK_W+PTR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0]       rom_rdata,
  output logic                    ram_we,
  output logic                    ram_re,
  output logic [BANK_W+PTR_W-1:0] ram_addr,
  output logic [DATA_W-1:0]       ram_wdata,
  input  logic [DATA_W-1:0]       ram_rdata
);
  logic rom_wait_w, ram_wait_w;

  bg_rom_reader #(
    .PTR_W(PTR_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
    .FAST_DLY(FAST_DLY), .SLOW_DLY(SLOW_DLY)
  ) u_rom (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_sel  (fast_sel),
    .ptr_wr    (ptr_wr),
    .ptr_val   (ptr_val),
    .rom_bank  (rom_bank),
    .rom_grant (rom_grant),
    .buf_rd_req(buf_rd_req),
    .rom_rdata (rom_rdata),
    .rom_rd    (rom_rd),
    .rom_addr  (rom_addr),
    .rd_buf    (rd_buf),
    .buf_ack   (buf_ack),
    .pending   (rom_pending),
    .rom_wait  (rom_wait_w)
  );

  bg_ram_poster #(
    .PTR_W(PTR_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
    .FAST_DLY(FAST_DLY), .SLOW_DLY(SLOW_DLY), .RAM_BASE_BANK(RAM_BASE_BANK)
  ) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast_sel (fast_sel),
    .st_req   (st_req),
    .st_addr  (st_addr),
    .st_data  (st_data),
    .ld_req   (ld_req),
    .ld_addr  (ld_addr),
    .ram_bank (ram_bank),
    .ram_grant(ram_grant),
    .ram_rdata(ram_rdata),
    .ram_we   (ram_we),
    .ram_re   (ram_re),
    .ram_addr (ram_addr),
    .ram_wdata(ram_wdata),
    .ld_ack   (ld_ack),
    .ld_data  (ld_data),
    .ram_wait (ram_wait_w)
  );

  assign stall = rom_wait_w || ram_wait_w;

  // R9: no memory is touched without its grant
  a_r9_rom_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> rom_grant);
  a_r9_ram_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> ram_grant);
  // R10: nothing requested and both grants present means no stall
  a_r10_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_rd_req && !st_req && !ld_req && rom_grant && ram_grant) |-> !stall);

endmodule

// File: tb/bg_mem_access_bench.sv
module bg_mem_access_bench;
  localparam int FAST = 5;
  localparam int SLOW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_sel = 1'b1, ptr_wr = 1'b0, rom_grant = 1'b1, buf_rd_req = 1'b0;
  logic [15:0] ptr_val = '0, st_addr = '0, ld_addr = '0;
  logic [7:0] rom_bank = 8'h05, ram_bank = 8'h00, st_data = '0;
  logic st_req = 1'b0, ld_req = 1'b0, ram_grant = 1'b1;
  logic buf_ack, rom_pending, ld_ack, stall, rom_rd, ram_we, ram_re;
  logic [7:0] rd_buf, ld_data, ram_wdata, rom_rdata, ram_rdata;
  logic [23:0] rom_addr, ram_addr;

  int checks = 0, fails = 0, cycles = 0, rd_pulses = 0;
  bit started = 1'b0;

  always #5 clk = ~clk;

  bg_mem_access u_bg_mem_access (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .ptr_wr(ptr_wr), .ptr_val(ptr_val),
    .rom_bank(rom_bank), .rom_grant(rom_grant), .buf_rd_req(buf_rd_req), .buf_ack(buf_ack),
    .rd_buf(rd_buf), .rom_pending(rom_pending), .st_req(st_req), .st_addr(st_addr),
    .st_data(st_data), .ld_req(ld_req), .ld_addr(ld_addr), .ld_ack(ld_ack), .ld_data(ld_data),
    .ram_bank(ram_bank), .ram_grant(ram_grant), .stall(stall), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] rom_byte(input logic [23:0] a);
    return (a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16]) + 8'h3C;
  endfunction
  function automatic int ram_idx(input logic [23:0] a);
    return int'({a[19:16], a[7:0]});
  endfunction

  // Memories seen by the design
  logic [7:0] phys [4096];
  assign rom_rdata = rom_byte(rom_addr);
  assign ram_rdata = phys[ram_idx(ram_addr)];
  always @(posedge clk) if (ram_we) phys[ram_idx(ram_addr)] = ram_wdata;

  // Behavioural reference model
  int m_rom_left, m_ram_left;
  logic [15:0] m_ptr, m_waddr;
  logic [7:0] m_wdata, m_buf;
  bit m_pend;
  logic [7:0] m_mem [4096];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_rom_left = 0; m_ram_left = 0; m_ptr = '0; m_waddr = '0;
      m_wdata = '0; m_buf = '0; m_pend = 0;
    end else begin
      if (ptr_wr) begin
        m_rom_left = fast_sel ? FAST : SLOW; m_ptr = ptr_val; m_pend = 1;
      end else if (m_rom_left == 1 && rom_grant) begin
        m_buf = rom_byte({rom_bank, m_ptr}); m_pend = 0; m_rom_left = 0;
      end else if (m_rom_left > 1) m_rom_left--;
      if (st_req && m_ram_left == 0) begin
        m_waddr = st_addr; m_wdata = st_data; m_ram_left = fast_sel ? FAST : SLOW;
      end else if (m_ram_left == 1 && ram_grant) begin
        m_mem[ram_idx({8'h70 + ram_bank, m_waddr})] = m_wdata; m_ram_left = 0;
      end else if (m_ram_left > 1) m_ram_left--;
    end
  end

  always @(negedge clk) begin
    if (rom_rd) rd_pulses++;
    if (rst_n && started) begin
      bit e_rd, e_back, e_we, e_re, e_stall;
      e_rd = (m_rom_left == 1) && rom_grant && !ptr_wr;
      chk("R2 rom_rd", rom_rd, e_rd);
      if (e_rd) chk("R3 rom_addr", rom_addr, {rom_bank, m_ptr});
      chk("R3 rd_buf", rd_buf, m_buf);
      chk("R3 pending", rom_pending, m_pend);
      e_back = buf_rd_req && m_rom_left == 0;
      chk("R5 buf_ack", buf_ack, e_back);
      e_we = (m_ram_left == 1) && ram_grant;
      chk("R6 ram_we", ram_we, e_we);
      if (e_we) begin
        chk("R6 ram_addr", ram_addr, {8'h70 + ram_bank, m_waddr});
        chk("R6 ram_wdata", ram_wdata, m_wdata);
      end
      e_re = ld_req && !st_req && m_ram_left == 0 && ram_grant;
      chk("R8 ram_re", ram_re, e_re);
      chk("R8 ld_ack", ld_ack, e_re);
      if (e_re) begin
        chk("R8 ld_addr", ram_addr, {8'h70 + ram_bank, ld_addr});
        chk("R8 ld_data", ld_data, m_mem[ram_idx({8'h70 + ram_bank, ld_addr})]);
      end
      e_stall = (m_rom_left == 1 && !rom_grant && !ptr_wr) || (buf_rd_req && m_rom_left != 0)
             || (m_ram_left == 1 && !ram_grant) || (st_req && m_ram_left != 0) || (ld_req && !e_re);
      chk("R10 stall", stall, e_stall);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_ptr(input logic [15:0] v);
    ptr_val = v; ptr_wr = 1'b1; tick(1); ptr_wr = 1'b0;
  endtask

  task automatic rom_latency(output int lat);
    lat = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rom_rd) break;
      lat++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
  endtask

  task automatic do_store(input logic [15:0] a, input logic [7:0] d, output int waits);
    bit ok;
    st_addr = a; st_data = d; st_req = 1'b1; waits = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); ok = !stall; if (!ok) waits++;
      @(posedge clk); #1;
      if (ok) break;
    end
    st_req = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] a, output logic [7:0] d, output int waits);
    bit ok;
    ld_addr = a; ld_req = 1'b1; waits = 0; d = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); ok = ld_ack; if (ok) d = ld_data; else waits++;
      @(posedge clk); #1;
      if (ok) break;
    end
    ld_req = 1'b0;
  endtask

  task automatic do_bufread(output logic [7:0] d, output int waits);
    bit ok;
    buf_rd_req = 1'b1; waits = 0; d = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); ok = buf_ack; if (ok) d = rd_buf; else waits++;
      @(posedge clk); #1;
      if (ok) break;
    end
    buf_rd_req = 1'b0;
  endtask

  initial begin
    int lat, w, p0;
    logic [7:0] d;
    for (int i = 0; i < 4096; i++) begin phys[i] = '0; m_mem[i] = '0; end
    tick(3);
    chk("R1 stall", stall, 0); chk("R1 pending", rom_pending, 0);
    chk("R1 rom_rd", rom_rd, 0); chk("R1 ram_we", ram_we, 0);
    chk("R1 ram_re", ram_re, 0); chk("R1 rd_buf", rd_buf, 0);
    rst_n = 1'b1; started = 1'b1; tick(2);

    // R2 fast and slow latency, R3 buffer contents
    write_ptr(16'h1234); rom_latency(lat); chk("R2 fast latency", lat, FAST);
    chk("R3 buffer", rd_buf, rom_byte(24'h051234));
    fast_sel = 1'b0; write_ptr(16'h00A0); rom_latency(lat); chk("R2 slow latency", lat, SLOW);
    chk("R3 buffer slow", rd_buf, rom_byte(24'h0500A0));

    // R5 buffer request behind a running read
    fast_sel = 1'b1; write_ptr(16'h2000); do_bufread(d, w);
    chk("R5 wait", w, FAST); chk("R5 data", d, rom_byte(24'h052000));

    // R4 restart and coincident write
    p0 = rd_pulses; write_ptr(16'h3000); tick(2); write_ptr(16'h3100); tick(10);
    chk("R4 restart pulses", rd_pulses - p0, 1); chk("R4 restart data", rd_buf, rom_byte(24'h053100));
    p0 = rd_pulses; write_ptr(16'h4000); tick(FAST - 1); write_ptr(16'h4100); tick(10);
    chk("R4 coincident pulses", rd_pulses - p0, 1); chk("R4 coincident data", rd_buf, rom_byte(24'h054100));

    // R11 clock select changed mid-count
    write_ptr(16'h5000); fast_sel = 1'b0; rom_latency(lat); chk("R11 latency", lat, FAST);
    fast_sel = 1'b1; tick(2);

    // R6 store then load, R7 back-to-back stores, R8 drain before load
    ram_bank = 8'h01;
    do_store(16'h0010, 8'hA5, w); chk("R6 idle store wait", w, 0);
    tick(8); do_load(16'h0010, d, w); chk("R6 stored byte", d, 8'hA5);
    do_store(16'h0020, 8'h11, w); do_store(16'h0021, 8'h22, w); chk("R7 second store wait", w, FAST);
    do_load(16'h0021, d, w); chk("R8 load wait", w, FAST); chk("R8 load data", d, 8'h22);
    do_load(16'h0020, d, w); chk("R8 first data", d, 8'h11);
    st_addr = 16'h0030; st_data = 8'h77; ld_addr = 16'h0030; st_req = 1'b1; ld_req = 1'b1;
    tick(1); st_req = 1'b0; do_load(16'h0030, d, w); chk("R8 same-cycle data", d, 8'h77);

    // R9 grants withheld
    rom_grant = 1'b0; write_ptr(16'h6000); tick(10);
    chk("R9 rom stall", stall, 1); chk("R9 rom pending", rom_pending, 1);
    rom_grant = 1'b1; tick(2);
    chk("R9 rom resumed", rom_pending, 0); chk("R9 rom data", rd_buf, rom_byte(24'h056000));
    ram_grant = 1'b0; do_store(16'h0040, 8'h9C, w); tick(10);
    chk("R9 ram stall", stall, 1);
    ram_grant = 1'b1; tick(2); do_load(16'h0040, d, w); chk("R9 ram data", d, 8'h9C);
    ram_grant = 1'b0; ld_addr = 16'h0040; ld_req = 1'b1; tick(3);
    chk("R9 load stall", stall, 1); ram_grant = 1'b1; do_load(16'h0040, d, w);
    chk("R9 load data", d, 8'h9C);

    // R10 idle
    tick(3); chk("R10 idle", stall, 0);

    // R1 reset in mid-transaction
    p0 = rd_pulses; write_ptr(16'h7000); do_store(16'h0050, 8'h55, w); tick(1);
    rst_n = 1'b0; started = 1'b0; tick(2);
    chk("R1 mid pending", rom_pending, 0); chk("R1 mid stall", stall, 0);
    rst_n = 1'b1; started = 1'b1; tick(12);
    chk("R1 no stale read", rd_pulses - p0, 0);
    do_load(16'h0050, d, w); chk("R1 no stale write", d, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule